// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Lock-Aware Replacement

This block caches virtual-to-physical page translations in a small fully associative array. Each slot keeps a virtual page number, a partition identifier, a context number, a flag for real (untranslated-context) mappings, a lock bit, a valid bit and a physical page number. Three ports work on the array. A lookup port compares a key with every slot and returns a registered hit, physical page and lock bit one cycle later. An insert port writes a new mapping. A demap port takes a command word and invalidates every slot that the command selects, all in one cycle.

On insert, the slot to write is chosen in this order. A slot that already holds the same key is overwritten in place. Failing that, the lowest-numbered invalid slot is used. When every slot is valid, a round-robin pointer picks the victim. The search starts one past the slot last replaced this way, wraps around, skips locked slots and never picks the pointer's own slot. If no candidate is found, the highest slot is overwritten and the pointer keeps its value.

The demap command word carries the virtual page, the real flag, a command kind and a context selector at fixed bit positions. The partition and two context values (primary and secondary) arrive on side inputs. An illegal command kind raises a one-cycle error pulse and changes nothing.

Top module: `tlb_lockrr`

## Requirements
- R1: After reset every slot is invalid: `lk_hit` and `dm_err` are 0, and any lookup misses.
- R2: A lookup hits when some slot is valid and its partition, real flag and virtual page equal the key, and its context equals the key's context (context not compared when the key's real flag is 1). `lk_hit`, `lk_ppn` and `lk_locked` show the result at the clock edge after the key is presented.
- R3: An insert whose key matches a valid slot (same matching rule as R2) overwrites that slot in place, including its physical page and lock bit, and leaves every other slot unchanged.
- R4: An insert with no matching slot writes the lowest-numbered invalid slot when one exists.
- R5: When all slots are valid, the victim is the first unlocked slot at offsets 1 to N-1 from the replacement pointer, counting upward modulo N. The pointer then moves to that slot. The pointer is 0 after reset.
- R6: When no slot at offsets 1 to N-1 is unlocked, slot N-1 is overwritten (even if locked) and the pointer is unchanged.
- R7: The demap kind is command bits [7:6]: 0 is page demap, 1 is context demap, 2 is partition demap. A page demap invalidates valid slots whose virtual page equals bits [63:13], whose real flag equals bit 9, and whose partition and context equal the selected values.
- R8: Context selector bits [5:4] choose the context: 0 is primary, 1 is secondary, 3 is forced zero, 2 is unsupported. With selector 2, page and context demaps have no effect, but a partition demap still executes.
- R9: A context demap invalidates valid non-real slots whose partition and context equal the selected values. A partition demap invalidates every valid slot of the given partition, real or not.
- R10: Kind 3 is illegal. `dm_err` is 1 for exactly the one cycle after the command, and no slot changes.
- R11: A slot freed by a demap is treated as invalid by the next insert, so R4 chooses it ahead of any round-robin victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert strobe |
| ins_vpn | input | 51 | Virtual page of the new mapping |
| ins_pid | input | 8 | Partition of the new mapping |
| ins_ctx | input | 13 | Context of the new mapping |
| ins_real | input | 1 | Real-mapping flag of the new mapping |
| ins_lock | input | 1 | Lock bit of the new mapping |
| ins_ppn | input | 28 | Physical page of the new mapping |
| lk_vpn | input | 51 | Lookup virtual page |
| lk_pid | input | 8 | Lookup partition |
| lk_ctx | input | 13 | Lookup context |
| lk_real | input | 1 | Lookup real flag |
| lk_hit | output | 1 | Registered lookup hit |
| lk_ppn | output | 28 | Registered physical page of the hit slot |
| lk_locked | output | 1 | Registered lock bit of the hit slot |
| dm_valid | input | 1 | Demap command strobe |
| dm_addr | input | 64 | Demap command word |
| dm_pid | input | 8 | Partition the demap applies to |
| dm_pri_ctx | input | 13 | Primary context value |
| dm_sec_ctx | input | 13 | Secondary context value |
| dm_err | output | 1 | One-cycle pulse for an illegal demap kind |

## Verification
A wrong replacement pointer or a wrong free-slot choice shows up at the lookup port only when an insert evicts a slot. The wrong mapping then disappears, so the bench looks up every slot its model holds after each insert and each demap. Any wrong victim or wrong invalidation therefore appears within a few lookups of the command that caused it. A wrong match rule or stale data shows on `lk_hit` or `lk_ppn` one cycle after the key is presented. A wrong decode of the command kind shows on `dm_err` in the cycle after the command.

// File: rtl/tlb_lockrr_pkg.sv
package tlb_lockrr_pkg;
  // demap kind, decoded from command word bits [7:6]
  typedef enum logic [1:0] {
    DM_PAGE = 2'd0,
    DM_CTX  = 2'd1,
    DM_ALL  = 2'd2,
    DM_BAD  = 2'd3
  } dm_kind_e;

  // context selector, decoded from command word bits [5:4]
  typedef enum logic [1:0] {
    CS_PRI  = 2'd0,
    CS_SEC  = 2'd1,
    CS_NONE = 2'd2,
    CS_ZERO = 2'd3
  } ctx_sel_e;
endpackage

// File: rtl/tlb_demap_dec.sv
module tlb_demap_dec
  import tlb_lockrr_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int VPN_LSB = 13,
  parameter int CTX_W   = 13,
  localparam int VPN_W  = ADDR_W - VPN_LSB
) (
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_word,
  input  logic [CTX_W-1:0]  pri_ctx,
  input  logic [CTX_W-1:0]  sec_ctx,
  output logic              do_page,
  output logic              do_ctx,
  output logic              do_all,
  output logic              bad_kind,
  output logic [VPN_W-1:0]  sel_vpn,
  output logic              sel_real,
  output logic [CTX_W-1:0]  sel_ctx
);
  dm_kind_e kind;
  ctx_sel_e csel;
  logic     ctx_ok;
  logic     unused_cmd_bits;

  assign kind     = dm_kind_e'(cmd_word[7:6]);
  assign csel     = ctx_sel_e'(cmd_word[5:4]);
  assign sel_vpn  = cmd_word[ADDR_W-1:VPN_LSB];
  assign sel_real = cmd_word[9];
  assign unused_cmd_bits = ^{cmd_word[VPN_LSB-1:10], cmd_word[8], cmd_word[3:0]};

  always_comb begin
    ctx_ok  = 1'b1;
    sel_ctx = '0;
    unique case (csel)
      CS_PRI:  sel_ctx = pri_ctx;
      CS_SEC:  sel_ctx = sec_ctx;
      CS_ZERO: sel_ctx = '0;
      default: ctx_ok  = 1'b0;
    endcase
  end

  assign do_page  = cmd_valid && (kind == DM_PAGE) && ctx_ok;
  assign do_ctx   = cmd_valid && (kind == DM_CTX)  && ctx_ok;
  assign do_all   = cmd_valid && (kind == DM_ALL);
  assign bad_kind = cmd_valid && (kind == DM_BAD);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pick,
  input  logic [N-1:0]     match_vec,
  input  logic [N-1:0]     valid_vec,
  input  logic [N-1:0]     lock_vec,
  output logic [IDX_W-1:0] idx,
  output logic             fallback
);
  logic [IDX_W-1:0] last_q, last_d;
  logic [IDX_W-1:0] m_idx, f_idx, r_idx;
  logic             m_found, f_found, r_found, rr_used;
  logic [IDX_W:0]   cand;

  // priority: matching slot, lowest free slot, round-robin unlocked slot
  always_comb begin
    m_found = 1'b0; m_idx = '0;
    f_found = 1'b0; f_idx = '0;
    r_found = 1'b0; r_idx = '0;
    cand    = '0;
    for (int i = 0; i < N; i++) begin
      if (!m_found && match_vec[i]) begin m_found = 1'b1; m_idx = IDX_W'(i); end
      if (!f_found && !valid_vec[i]) begin f_found = 1'b1; f_idx = IDX_W'(i); end
    end
    for (int k = 1; k < N; k++) begin
      cand = {1'b0, last_q} + (IDX_W+1)'(k);
      if (cand >= (IDX_W+1)'(N)) cand = cand - (IDX_W+1)'(N);
      if (!r_found && !lock_vec[cand[IDX_W-1:0]]) begin
        r_found = 1'b1;
        r_idx   = cand[IDX_W-1:0];
      end
    end
  end

  assign rr_used  = !m_found && !f_found && r_found;
  assign fallback = !m_found && !f_found && !r_found;

  always_comb begin
    if (m_found)      idx = m_idx;
    else if (f_found) idx = f_idx;
    else if (r_found) idx = r_idx;
    else              idx = IDX_W'(N-1);
  end

  always_comb begin
    last_d = last_q;
    if (pick && rr_used) last_d = r_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_d;
  end

  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pick && fallback) |=> $stable(last_q));
  a_r5_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (pick && rr_used) |=> (last_q == $past(idx)));
endmodule

// File: rtl/tlb_lockrr.sv
module tlb_lockrr #(
  parameter int N       = 8,
  parameter int ADDR_W  = 64,
  parameter int VPN_LSB = 13,
  parameter int PID_W   = 8,
  parameter int CTX_W   = 13,
  parameter int PPN_W   = 28,
  localparam int VPN_W  = ADDR_W - VPN_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [PID_W-1:0]  ins_pid,
  input  logic [CTX_W-1:0]  ins_ctx,
  input  logic              ins_real,
  input  logic              ins_lock,
  input  logic [PPN_W-1:0]  ins_ppn,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [PID_W-1:0]  lk_pid,
  input  logic [CTX_W-1:0]  lk_ctx,
  input  logic              lk_real,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic              lk_locked,
  input  logic              dm_valid,
  input  logic [ADDR_W-1:0] dm_addr,
  input  logic [PID_W-1:0]  dm_pid,
  input  logic [CTX_W-1:0]  dm_pri_ctx,
  input  logic [CTX_W-1:0]  dm_sec_ctx,
  output logic              dm_err
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  // slot storage: valid has reset, payload is written under enable only
  logic [N-1:0]     v_q, v_d;
  logic [N-1:0]     lock_q;
  logic [N-1:0]     real_q;
  logic [VPN_W-1:0] vpn_q [N];
  logic [PID_W-1:0] pid_q [N];
  logic [CTX_W-1:0] ctx_q [N];
  logic [PPN_W-1:0] ppn_q [N];

  logic [N-1:0]     lk_match, ins_match, dm_kill, we;
  logic [IDX_W-1:0] vic_idx;
  logic             vic_fb;

  logic             do_page, do_ctx, do_all, bad_kind, sel_real;
  logic [VPN_W-1:0] sel_vpn;
  logic [CTX_W-1:0] sel_ctx;

  logic             hit_d, lock_d;
  logic [PPN_W-1:0] ppn_d;
  logic             err_q;

  tlb_demap_dec #(.ADDR_W(ADDR_W), .VPN_LSB(VPN_LSB), .CTX_W(CTX_W)) i_dec (
    .cmd_valid (dm_valid),
    .cmd_word  (dm_addr),
    .pri_ctx   (dm_pri_ctx),
    .sec_ctx   (dm_sec_ctx),
    .do_page   (do_page),
    .do_ctx    (do_ctx),
    .do_all    (do_all),
    .bad_kind  (bad_kind),
    .sel_vpn   (sel_vpn),
    .sel_real  (sel_real),
    .sel_ctx   (sel_ctx)
  );

  tlb_victim #(.N(N)) i_vic (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick      (ins_valid),
    .match_vec (ins_match),
    .valid_vec (v_q),
    .lock_vec  (lock_q),
    .idx       (vic_idx),
    .fallback  (vic_fb)
  );

  // per-slot comparators
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic base_pid_dm;
    assign lk_match[g]  = v_q[g] && (pid_q[g] == lk_pid) && (real_q[g] == lk_real) &&
                          (vpn_q[g] == lk_vpn) && (lk_real || (ctx_q[g] == lk_ctx));
    assign ins_match[g] = v_q[g] && (pid_q[g] == ins_pid) && (real_q[g] == ins_real) &&
                          (vpn_q[g] == ins_vpn) && (ins_real || (ctx_q[g] == ins_ctx));
    assign base_pid_dm  = v_q[g] && (pid_q[g] == dm_pid);
    assign dm_kill[g]   = (do_page && base_pid_dm && (real_q[g] == sel_real) &&
                           (vpn_q[g] == sel_vpn) && (ctx_q[g] == sel_ctx)) ||
                          (do_ctx && base_pid_dm && !real_q[g] && (ctx_q[g] == sel_ctx)) ||
                          (do_all && base_pid_dm);
    assign we[g]        = ins_valid && (vic_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (we[g]) begin
        vpn_q[g]  <= ins_vpn;
        pid_q[g]  <= ins_pid;
        ctx_q[g]  <= ins_ctx;
        ppn_q[g]  <= ins_ppn;
        real_q[g] <= ins_real;
        lock_q[g] <= ins_lock;
      end
    end
  end

  // valid next state: demap clears, insert sets (insert wins on its slot)
  always_comb begin
    v_d = v_q & ~dm_kill;
    if (ins_valid) v_d[vic_idx] = 1'b1;
  end

  // lookup result mux
  always_comb begin
    hit_d  = |lk_match;
    ppn_d  = '0;
    lock_d = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i]) begin
        ppn_d  = ppn_d | ppn_q[i];
        lock_d = lock_d | lock_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= '0;
      lk_hit <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      v_q    <= v_d;
      lk_hit <= hit_d;
      err_q  <= bad_kind;
    end
  end

  always_ff @(posedge clk) begin
    lk_ppn    <= ppn_d;
    lk_locked <= lock_d;
  end

  assign dm_err = err_q;

  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  a_r10_bad_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_valid && dm_addr[7:6] == 2'b11 && !ins_valid) |=> (v_q == $past(v_q)));
  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    dm_err |-> $past(dm_valid));
  a_r4_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !(|ins_match) && !(&v_q)) |-> !v_q[vic_idx]);
  a_r6_lock_spared: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !(|ins_match) && (&v_q) && !vic_fb) |-> !lock_q[vic_idx]);
endmodule

// File: tb/test_tlb_lockrr.sv
`timescale 1ns/1ps
module test_tlb_lockrr;
  localparam int N = 8;
  localparam time CLK_P = 20ns;

  logic        clk, rst_n;
  logic        ins_valid, ins_real, ins_lock;
  logic [50:0] ins_vpn, lk_vpn;
  logic [7:0]  ins_pid, lk_pid, dm_pid;
  logic [12:0] ins_ctx, lk_ctx, dm_pri_ctx, dm_sec_ctx;
  logic [27:0] ins_ppn, lk_ppn;
  logic        lk_real, lk_hit, lk_locked, dm_valid, dm_err;
  logic [63:0] dm_addr;

  int total = 0;
  int bad = 0;

  // reference model
  logic        m_v [N];
  logic        m_lock [N];
  logic        m_real [N];
  logic [50:0] m_vpn [N];
  logic [7:0]  m_pid [N];
  logic [12:0] m_ctx [N];
  logic [27:0] m_ppn [N];
  int          m_last;

  tlb_lockrr i_tlb_lockrr (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_pid(ins_pid), .ins_ctx(ins_ctx),
    .ins_real(ins_real), .ins_lock(ins_lock), .ins_ppn(ins_ppn),
    .lk_vpn(lk_vpn), .lk_pid(lk_pid), .lk_ctx(lk_ctx), .lk_real(lk_real),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_locked(lk_locked),
    .dm_valid(dm_valid), .dm_addr(dm_addr), .dm_pid(dm_pid),
    .dm_pri_ctx(dm_pri_ctx), .dm_sec_ctx(dm_sec_ctx), .dm_err(dm_err)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int mdl_find(logic [50:0] vpn, logic [7:0] pid, logic [12:0] ctx, logic rl);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_pid[i] == pid && m_real[i] == rl && m_vpn[i] == vpn &&
          (rl || m_ctx[i] == ctx)) return i;
    return -1;
  endfunction

  task automatic do_lookup(input string req, input logic [50:0] vpn, input logic [7:0] pid,
                           input logic [12:0] ctx, input logic rl);
    int e;
    lk_vpn = vpn; lk_pid = pid; lk_ctx = ctx; lk_real = rl;
    e = mdl_find(vpn, pid, ctx, rl);
    @(posedge clk);
    @(negedge clk);
    chk(req, "lk_hit", 64'(lk_hit), 64'(e >= 0));
    if (e >= 0) begin
      chk(req, "lk_ppn", 64'(lk_ppn), 64'(m_ppn[e]));
      chk(req, "lk_locked", 64'(lk_locked), 64'(m_lock[e]));
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < N; i++)
      if (m_v[i]) do_lookup(req, m_vpn[i], m_pid[i], m_ctx[i], m_real[i]);
  endtask

  task automatic do_insert(input string req, input logic [50:0] vpn, input logic [7:0] pid,
                           input logic [12:0] ctx, input logic rl, input logic lk,
                           input logic [27:0] ppn);
    int vi, f;
    logic [50:0] o_vpn; logic [7:0] o_pid; logic [12:0] o_ctx; logic o_real, o_v;
    vi = mdl_find(vpn, pid, ctx, rl);
    if (vi < 0) begin
      f = -1;
      for (int i = N-1; i >= 0; i--) if (!m_v[i]) f = i;
      if (f >= 0) vi = f;
      else begin
        for (int k = N-1; k >= 1; k--)
          if (!m_lock[(m_last + k) % N]) vi = (m_last + k) % N;
        if (vi >= 0) m_last = vi;
        else vi = N-1;
      end
    end
    o_v = m_v[vi]; o_vpn = m_vpn[vi]; o_pid = m_pid[vi]; o_ctx = m_ctx[vi]; o_real = m_real[vi];
    ins_vpn = vpn; ins_pid = pid; ins_ctx = ctx; ins_real = rl; ins_lock = lk; ins_ppn = ppn;
    ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    m_v[vi] = 1'b1; m_vpn[vi] = vpn; m_pid[vi] = pid; m_ctx[vi] = ctx;
    m_real[vi] = rl; m_lock[vi] = lk; m_ppn[vi] = ppn;
    if (o_v) do_lookup(req, o_vpn, o_pid, o_ctx, o_real);
    sweep(req);
  endtask

  task automatic do_demap(input string req, input logic [50:0] vpn, input logic rl,
                          input logic [1:0] typ, input logic [1:0] sel, input logic [7:0] pid,
                          input logic [12:0] pri, input logic [12:0] sec);
    logic [12:0] c; logic ign;
    logic [63:0] a;
    a = {vpn, 13'b0}; a[9] = rl; a[7:6] = typ; a[5:4] = sel;
    ign = (sel == 2'd2);
    c = (sel == 2'd0) ? pri : (sel == 2'd1) ? sec : 13'd0;
    dm_addr = a; dm_pid = pid; dm_pri_ctx = pri; dm_sec_ctx = sec; dm_valid = 1'b1;
    @(negedge clk);
    dm_valid = 1'b0;
    chk("R10", "dm_err", 64'(dm_err), 64'(typ == 2'd3));
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && m_pid[i] == pid) begin
        if (typ == 2'd0 && !ign && m_real[i] == rl && m_vpn[i] == vpn && m_ctx[i] == c) m_v[i] = 1'b0;
        if (typ == 2'd1 && !ign && !m_real[i] && m_ctx[i] == c) m_v[i] = 1'b0;
        if (typ == 2'd2) m_v[i] = 1'b0;
      end
    end
    sweep(req);
  endtask

  initial begin
    ins_valid = 0; ins_vpn = 0; ins_pid = 0; ins_ctx = 0; ins_real = 0; ins_lock = 0; ins_ppn = 0;
    lk_vpn = 0; lk_pid = 0; lk_ctx = 0; lk_real = 0;
    dm_valid = 0; dm_addr = 0; dm_pid = 0; dm_pri_ctx = 0; dm_sec_ctx = 0;
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_lock[i] = 0; m_real[i] = 0; m_vpn[i] = 0; m_pid[i] = 0; m_ctx[i] = 0; m_ppn[i] = 0;
    end
    m_last = 0;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "lk_hit after reset", 64'(lk_hit), 64'd0);
    chk("R1", "dm_err after reset", 64'(dm_err), 64'd0);
    do_lookup("R1", 51'd100, 8'd0, 13'd1, 1'b0);

    // R4: fill free slots in order; slots 2 and 5 locked
    for (int i = 0; i < N; i++)
      do_insert("R4", 51'(100 + i), 8'd0, 13'd1, 1'b0, (i == 2 || i == 5), 28'(16'hA000 + i));
    // R2: context mismatch misses, real key ignores context
    do_lookup("R2", 51'd103, 8'd0, 13'd2, 1'b0);
    // R5: round robin from pointer 0 evicts slot 1, then 3 (skipping locked 2)
    do_insert("R5", 51'd200, 8'd0, 13'd1, 1'b0, 1'b0, 28'hB001);
    do_insert("R5", 51'd201, 8'd0, 13'd1, 1'b0, 1'b0, 28'hB002);
    // R3: same key, new data, in place
    do_insert("R3", 51'd104, 8'd0, 13'd1, 1'b0, 1'b1, 28'hC104);
    // R6: lock everything, then force fallback to slot N-1
    for (int i = 0; i < 10; i++)
      do_insert("R6", 51'(300 + i), 8'd0, 13'd1, 1'b0, 1'b1, 28'(20'hD0000 + i));
    do_insert("R6", 51'd400, 8'd0, 13'd1, 1'b0, 1'b0, 28'hE400);
    do_insert("R6", 51'd401, 8'd0, 13'd1, 1'b0, 1'b1, 28'hE401);

    // R10: illegal kind changes nothing
    do_demap("R10", 51'd300, 1'b0, 2'd3, 2'd0, 8'd0, 13'd1, 13'd0);
    @(negedge clk);
    chk("R10", "dm_err one cycle", 64'(dm_err), 64'd0);
    // R8: unsupported selector, page demap ignored, partition demap executes
    do_demap("R8", 51'd300, 1'b0, 2'd0, 2'd2, 8'd0, 13'd1, 13'd1);
    do_demap("R8", 51'd0, 1'b0, 2'd2, 2'd2, 8'd0, 13'd1, 13'd1);

    // refill with mixed entries for page and context demaps
    do_insert("R2", 51'd10, 8'd1, 13'd0, 1'b1, 1'b0, 28'h1010);
    do_lookup("R2", 51'd10, 8'd1, 13'd7, 1'b1);
    do_insert("R7", 51'd11, 8'd1, 13'd5, 1'b0, 1'b0, 28'h1011);
    do_insert("R7", 51'd12, 8'd1, 13'd5, 1'b0, 1'b0, 28'h1012);
    do_insert("R9", 51'd13, 8'd1, 13'd6, 1'b0, 1'b0, 28'h1013);
    do_insert("R9", 51'd14, 8'd1, 13'd0, 1'b0, 1'b0, 28'h1014);
    do_insert("R9", 51'd14, 8'd2, 13'd5, 1'b0, 1'b0, 28'h2014);
    do_demap("R7", 51'd11, 1'b0, 2'd0, 2'd1, 8'd1, 13'd0, 13'd5);
    do_demap("R7", 51'd10, 1'b1, 2'd0, 2'd3, 8'd1, 13'd9, 13'd9);
    do_demap("R9", 51'd0, 1'b0, 2'd1, 2'd0, 8'd1, 13'd5, 13'd0);
    do_demap("R8", 51'd0, 1'b0, 2'd1, 2'd3, 8'd1, 13'd5, 13'd5);
    // R11: freed slots reused first
    do_insert("R11", 51'd50, 8'd1, 13'd6, 1'b0, 1'b0, 28'h5050);
    do_insert("R11", 51'd51, 8'd1, 13'd6, 1'b0, 1'b0, 28'h5051);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [50:0] rv; logic [7:0] rp; logic [12:0] rc; logic rr;
      op = $urandom % 10;
      rv = 51'($urandom % 12); rp = 8'($urandom % 2); rc = 13'($urandom % 3);
      rr = (($urandom % 4) == 0);
      if (op < 6)
        do_insert("R5", rv, rp, rc, rr, (($urandom % 5) == 0), 28'($urandom));
      else if (op < 8)
        do_lookup("R2", rv, rp, rc, rr);
      else
        do_demap("R9", rv, rr, 2'($urandom % 4), 2'($urandom % 4), rp,
                 13'($urandom % 3), 13'($urandom % 3));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule